// File: doc/BRIEF.md
# Prescaled Multi-Mode Countdown Timer

This block has two independent 16-bit countdown channels behind a small register port. Each channel has a load register, a current-value register that can only be read, and a control register. The control register turns the channel on, picks one of four counting modes and picks a prescale code. The prescaler divides the system clock by 1 or by a power of two from 4 to 65536, and each prescaled tick moves the counter one step.

When a channel expires it sets a sticky interrupt flag. The flag drives that channel's level interrupt output until software writes a one to the flag's bit in the shared status register. One of the timeout modes also sets a reset-request flag in the same register. A system controller can use that flag to request a reset.

Writes take effect on the rising clock edge while `bus_wr` is high. Reads are combinational from `bus_addr`. An address that is not mapped reads as zero, and a write to it does nothing.

Top module: `tmr_block`

## Requirements
- R1: Reset brings every load, value, control and status bit to zero and holds `irq` low.
- R2: Register layout, with channel n counted from 0:
  - Status is at 0x00. Channel n has load at 0x10*(n+1), value at 0x10*(n+1)+4 and control at 0x10*(n+1)+8.
  - In control, bit 7 is enable, bits 5:4 are mode and bits 3:0 are the prescale code. Bit 6 and bits 31:8 read as 0.
  - Load keeps bits 15:0 of the written word.
- R3: The value is copied from load, and the prescaler restarts from zero, in two cases: a control write that turns enable from 0 to 1, and a load write while the channel is enabled. A load write while the channel is disabled leaves the value unchanged.
- R4: Prescale code 0 gives one count step every clock cycle while the channel is enabled. Code n from 1 to 15 gives one step every 2^(n+1) cycles, the first step falling 2^(n+1) cycles after a restart.
- R5: Mode 1 (periodic): a step taken at value 1 or 0 reloads the value from load and sets the channel's interrupt flag. Any other step decrements the value.
- R6: Mode 0 (free-running): the value decrements, and a step taken at 0 wraps it to 0xFFFF and sets the interrupt flag.
- R7: Mode 2 (timeout): the step from 1 to 0 sets the interrupt flag. The value then stays at 0 and raises no further flags.
- R8: Mode 3 acts like mode 2 and also sets the channel's reset-request flag, which is status bit 4+n.
- R9: Status bits n and 4+n are cleared by writing 1 to them. Writing 0 has no effect. A flag set in the same cycle as its clear stays set.
- R10: `irq[n]` is high exactly while channel n's interrupt flag is set. Activity on one channel never changes the other channel's registers.
- R11: A disabled channel holds its value. Writes to the value register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 2 | Per-channel level interrupt |

## Verification
The bench checks that periodic mode reloads on the step that reaches the end of the count rather than one step late; a design one step late would read back 0 where the reload value is expected. It rewrites the load register in the middle of a prescale period. A design that does not restart the prescaler would then take its next step two cycles early. A clear written in the same cycle as a mode-3 expiry must leave both flags set; a design that let the clear win would silently lose an expiry. The bench also confirms that a timeout channel parked at zero raises no second flag, that a free-running counter flags only on the wrap, and that a disabled channel ignores both value writes and the passage of time.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PSEL_W       = 4;
    localparam int CH_STRIDE    = 16;
    localparam int OFF_STATUS   = 0;
    localparam int OFF_LOAD     = 0;
    localparam int OFF_VALUE    = 4;
    localparam int OFF_CTL      = 8;
    localparam int STAT_RST_LSB = 4;
    localparam int CTL_EN_BIT   = 7;

    typedef enum logic [1:0] {
        MODE_FREE        = 2'd0,
        MODE_PERIODIC    = 2'd1,
        MODE_ONESHOT     = 2'd2,
        MODE_ONESHOT_RST = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic             en;
        tmr_mode_e        mode;
        logic [PSEL_W-1:0] psel;
    } tmr_ctl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);
    // The largest divisor is 2^(2^PSEL_W), so the counter needs 2^PSEL_W bits.
    localparam int PRE_W = 2 ** PSEL_W;
    localparam logic [PRE_W:0]    POW_ONE = 1;
    localparam logic [PSEL_W:0]   SH_ONE  = 1;
    localparam logic [PRE_W-1:0]  CNT_ONE = 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t       pre_d, pre_q;
    logic [PSEL_W:0]  shamt;
    logic [PRE_W:0]   pow, pow_m1;
    logic [PRE_W-1:0] lim;

    always_comb begin
        shamt  = {1'b0, psel} + SH_ONE;
        pow    = POW_ONE << shamt;
        pow_m1 = pow - POW_ONE;
        lim    = (psel == '0) ? '0 : pow_m1[PRE_W-1:0];
        tick   = en && !restart && (pre_q.cnt >= lim);
        pre_d  = pre_q;
        if (!en || restart || tick) pre_d.cnt = '0;
        else                        pre_d.cnt = pre_q.cnt + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // After a restart, the next step waits a whole period unless the divisor is 1.
    assert_restart_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && lim != '0) |=> (!tick || lim == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load,
    input  logic             wr_ctl,
    input  logic [CNT_W-1:0] load_in,
    input  tmr_ctl_t         ctl_in,
    input  logic             clr_int,
    input  logic             clr_rst,
    output logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] load,
    output tmr_ctl_t         ctl,
    output logic             int_flag,
    output logic             rst_flag
);
    localparam logic [CNT_W-1:0] ONE  = 1;
    localparam logic [CNT_W-1:0] ALL1 = '1;

    typedef struct packed {
        tmr_ctl_t         ctl;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] value;
        logic             intf;
        logic             rstf;
    } ch_state_t;

    ch_state_t ch_d, ch_q;
    logic      start, tick, expire, rst_evt;

    // A start is an enable edge or a reload while running.
    assign start = (wr_ctl && ctl_in.en && !ch_q.ctl.en) || (wr_load && ch_q.ctl.en);

    tmr_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ch_q.ctl.en),
        .restart (start),
        .psel    (ch_q.ctl.psel),
        .tick    (tick)
    );

    always_comb begin
        ch_d    = ch_q;
        expire  = 1'b0;
        rst_evt = 1'b0;
        if (wr_ctl)  ch_d.ctl  = ctl_in;
        if (wr_load) ch_d.load = load_in;
        if (start) begin
            ch_d.value = wr_load ? load_in : ch_q.load;
        end else if (tick) begin
            case (ch_q.ctl.mode)
                MODE_FREE: begin
                    if (ch_q.value == '0) begin
                        ch_d.value = ALL1;
                        expire     = 1'b1;
                    end else begin
                        ch_d.value = ch_q.value - ONE;
                    end
                end
                MODE_PERIODIC: begin
                    if (ch_q.value <= ONE) begin
                        ch_d.value = ch_q.load;
                        expire     = 1'b1;
                    end else begin
                        ch_d.value = ch_q.value - ONE;
                    end
                end
                default: begin
                    if (ch_q.value == ONE) begin
                        ch_d.value = '0;
                        expire     = 1'b1;
                        rst_evt    = (ch_q.ctl.mode == MODE_ONESHOT_RST);
                    end else if (ch_q.value != '0) begin
                        ch_d.value = ch_q.value - ONE;
                    end
                end
            endcase
        end
        // A hardware set wins over a software clear in the same cycle.
        ch_d.intf = (ch_q.intf && !clr_int) || expire;
        ch_d.rstf = (ch_q.rstf && !clr_rst) || rst_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign value    = ch_q.value;
    assign load     = ch_q.load;
    assign ctl      = ch_q.ctl;
    assign int_flag = ch_q.intf;
    assign rst_flag = ch_q.rstf;

    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.ctl.en && ch_q.ctl.mode[1] && ch_q.value == '0 && !wr_load && !wr_ctl)
        |=> (ch_q.value == '0 && !$rose(ch_q.intf)));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.intf && !clr_int) |=> ch_q.intf);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_q.ctl.en && !wr_ctl) |=> $stable(ch_q.value));

    assert_rst_with_int_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_q.rstf) |-> ch_q.intf);

    assert_w1c_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.intf && clr_int && !ch_q.ctl.en && !wr_ctl) |=> !ch_q.intf);

endmodule

// File: rtl/tmr_block.sv
module tmr_block
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,   // up to 4: the status field packs one flag per channel below bit 4
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    function automatic logic [ADDR_W-1:0] reg_addr(input int ch, input int off);
        return ADDR_W'((ch + 1) * CH_STRIDE + off);
    endfunction

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(OFF_STATUS);

    tmr_ctl_t          ctl_wr;
    logic [CNT_W-1:0]  val_a  [NUM_CH];
    logic [CNT_W-1:0]  load_a [NUM_CH];
    tmr_ctl_t          ctl_a  [NUM_CH];
    logic [NUM_CH-1:0] intf_a, rstf_a;
    logic              stat_wr;
    logic              unused_wdata;

    assign ctl_wr       = {bus_wdata[CTL_EN_BIT], bus_wdata[5:4], bus_wdata[PSEL_W-1:0]};
    assign stat_wr      = bus_wr && (bus_addr == STAT_ADDR);
    assign unused_wdata = ^{bus_wdata[DATA_W-1:CNT_W], bus_wdata[6]};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_load  (bus_wr && bus_addr == reg_addr(c, OFF_LOAD)),
            .wr_ctl   (bus_wr && bus_addr == reg_addr(c, OFF_CTL)),
            .load_in  (bus_wdata[CNT_W-1:0]),
            .ctl_in   (ctl_wr),
            .clr_int  (stat_wr && bus_wdata[c]),
            .clr_rst  (stat_wr && bus_wdata[STAT_RST_LSB+c]),
            .value    (val_a[c]),
            .load     (load_a[c]),
            .ctl      (ctl_a[c]),
            .int_flag (intf_a[c]),
            .rst_flag (rstf_a[c])
        );
    end

    assign irq = intf_a;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STAT_ADDR) begin
            for (int c = 0; c < NUM_CH; c++) begin
                bus_rdata[c]              = intf_a[c];
                bus_rdata[STAT_RST_LSB+c] = rstf_a[c];
            end
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == reg_addr(c, OFF_LOAD))  bus_rdata = DATA_W'(load_a[c]);
            if (bus_addr == reg_addr(c, OFF_VALUE)) bus_rdata = DATA_W'(val_a[c]);
            if (bus_addr == reg_addr(c, OFF_CTL))
                bus_rdata = DATA_W'({ctl_a[c].en, 1'b0, ctl_a[c].mode, ctl_a[c].psel});
        end
    end

endmodule

// File: tb/tmr_block_tb_top.sv
module tmr_block_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tmr_block dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // kind: 0 write, 1 read-compare, 2 idle cycles, 3 irq compare
    localparam int NV = 58;
    localparam logic [45:0] VEC [NV] = '{
        {2'd1, 4'd1,  8'h00, 32'h0},          // R1 status after reset
        {2'd1, 4'd1,  8'h14, 32'h0},          // R1
        {2'd1, 4'd1,  8'h18, 32'h0},          // R1
        {2'd3, 4'd1,  8'h00, 32'h0},          // R1 irq low
        {2'd0, 4'd2,  8'h10, 32'h000ABCD5},   // R2 load keeps low 16 bits
        {2'd1, 4'd2,  8'h10, 32'h0000BCD5},
        {2'd1, 4'd3,  8'h14, 32'h0},          // R3 disabled load write leaves value
        {2'd0, 4'd2,  8'h28, 32'h00000F7F},   // R2 bit 6 and high bits dropped
        {2'd1, 4'd2,  8'h28, 32'h0000003F},
        {2'd0, 4'd2,  8'h28, 32'h0},
        {2'd0, 4'd11, 8'h14, 32'h00001234},   // R11 value write ignored
        {2'd1, 4'd11, 8'h14, 32'h0},
        {2'd0, 4'd3,  8'h10, 32'h5},          // periodic, divide-by-1
        {2'd0, 4'd3,  8'h18, 32'h90},
        {2'd1, 4'd3,  8'h14, 32'h5},          // R3 enable copies load
        {2'd2, 4'd4,  8'h00, 32'd3},
        {2'd1, 4'd4,  8'h14, 32'h2},          // R4 one step per cycle
        {2'd2, 4'd5,  8'h00, 32'd2},
        {2'd1, 4'd5,  8'h14, 32'h5},          // R5 reload at end of count
        {2'd1, 4'd5,  8'h00, 32'h1},          // R5 flag
        {2'd3, 4'd10, 8'h00, 32'h1},          // R10 irq
        {2'd0, 4'd11, 8'h18, 32'h10},         // disable, last step taken
        {2'd1, 4'd11, 8'h14, 32'h4},
        {2'd2, 4'd11, 8'h00, 32'd3},
        {2'd1, 4'd11, 8'h14, 32'h4},          // R11 hold while disabled
        {2'd0, 4'd9,  8'h00, 32'h0},          // R9 zero write no effect
        {2'd1, 4'd9,  8'h00, 32'h1},
        {2'd0, 4'd9,  8'h00, 32'h1},
        {2'd1, 4'd9,  8'h00, 32'h0},          // R9 cleared
        {2'd3, 4'd10, 8'h00, 32'h0},          // R10 irq follows
        {2'd0, 4'd6,  8'h10, 32'h2},          // free-running, divide-by-8
        {2'd0, 4'd6,  8'h18, 32'h82},
        {2'd1, 4'd6,  8'h14, 32'h2},
        {2'd2, 4'd4,  8'h00, 32'd7},
        {2'd1, 4'd4,  8'h14, 32'h2},          // R4 no step before 8 cycles
        {2'd2, 4'd4,  8'h00, 32'd1},
        {2'd1, 4'd4,  8'h14, 32'h1},          // R4 step at 8
        {2'd2, 4'd6,  8'h00, 32'd8},
        {2'd1, 4'd6,  8'h14, 32'h0},
        {2'd1, 4'd6,  8'h00, 32'h0},          // R6 no flag on reaching zero
        {2'd2, 4'd6,  8'h00, 32'd8},
        {2'd1, 4'd6,  8'h14, 32'h0000FFFF},   // R6 wrap
        {2'd1, 4'd6,  8'h00, 32'h1},          // R6 flag on wrap
        {2'd0, 4'd6,  8'h18, 32'h02},
        {2'd0, 4'd9,  8'h00, 32'h1},
        {2'd1, 4'd9,  8'h00, 32'h0},
        {2'd0, 4'd3,  8'h20, 32'hA},          // ch1 periodic divide-by-4
        {2'd0, 4'd3,  8'h28, 32'h91},
        {2'd2, 4'd3,  8'h00, 32'd1},
        {2'd0, 4'd3,  8'h20, 32'h14},         // reload mid-period
        {2'd1, 4'd3,  8'h24, 32'h14},         // R3 value from new load
        {2'd2, 4'd4,  8'h00, 32'd3},
        {2'd1, 4'd4,  8'h24, 32'h14},         // R3 prescaler restarted
        {2'd2, 4'd4,  8'h00, 32'd1},
        {2'd1, 4'd4,  8'h24, 32'h13},
        {2'd0, 4'd10, 8'h28, 32'h11},
        {2'd1, 4'd10, 8'h14, 32'h0000FFFF},   // R10 ch0 untouched
        {2'd1, 4'd10, 8'h00, 32'h0}
    };

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] e);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s addr 0x%02h: actual 0x%08h expected 0x%08h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic chk_irq(input string tag, input logic [1:0] e);
        #1;
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s irq: actual %b expected %b", tag, irq, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        idle(3);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            automatic logic [45:0] v   = VEC[i];
            automatic string       tag = $sformatf("R%0d", v[43:40]);
            case (v[45:44])
                2'd0: wr_reg(v[39:32], v[31:0]);
                2'd1: chk_rd(tag, v[39:32], v[31:0]);
                2'd2: idle(int'(v[31:0]));
                default: chk_irq(tag, v[1:0]);
            endcase
        end

        // R7: ch1 timeout mode, divide-by-1, load 3
        wr_reg(8'h20, 32'h3);
        wr_reg(8'h28, 32'hA0);
        idle(2);
        chk_rd("R7", 8'h24, 32'h1);
        chk_rd("R7", 8'h00, 32'h0);
        idle(1);
        chk_rd("R7", 8'h24, 32'h0);
        chk_rd("R7", 8'h00, 32'h2);
        chk_irq("R10", 2'b10);
        idle(5);
        chk_rd("R7", 8'h24, 32'h0);
        wr_reg(8'h00, 32'h2);
        chk_rd("R9", 8'h00, 32'h0);
        idle(3);
        chk_rd("R7", 8'h00, 32'h0);            // no second expiry at zero
        chk_irq("R10", 2'b00);

        // R8: ch0 mode 3, clear written on the expiry cycle
        wr_reg(8'h10, 32'h2);
        wr_reg(8'h18, 32'hB0);
        idle(1);
        wr_reg(8'h00, 32'h11);                 // R9 set wins over clear
        chk_rd("R8", 8'h00, 32'h11);
        chk_rd("R8", 8'h14, 32'h0);
        chk_irq("R8", 2'b01);
        wr_reg(8'h00, 32'h10);
        chk_rd("R9", 8'h00, 32'h01);
        wr_reg(8'h00, 32'h01);
        chk_rd("R9", 8'h00, 32'h0);

        // R1: reset while ch0 runs periodic
        wr_reg(8'h10, 32'h9);
        wr_reg(8'h18, 32'h90);
        idle(2);
        rst_n = 1'b0;
        idle(1);
        chk_rd("R1", 8'h00, 32'h0);
        chk_rd("R1", 8'h10, 32'h0);
        chk_rd("R1", 8'h14, 32'h0);
        chk_rd("R1", 8'h18, 32'h0);
        chk_irq("R1", 2'b00);
        rst_n = 1'b1;
        idle(2);
        chk_rd("R1", 8'h14, 32'h0);

        done = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

endmodule